// File: doc/BRIEF.md
# Indirect 32-bit Switch Register Access over MDIO

This block is a management master that reaches the 32-bit internal registers of an Ethernet switch. The switch offers only 16-bit management registers on a Clause 22 MDIO bus, so every access is made indirectly. First the switch is told which register is wanted. Then the value is moved. Every 32-bit quantity crosses the bus as two 16-bit frames, upper half first. The 5-bit MDIO register field of each frame carries the switch identifier, a phase selector and a direction bit.

The host gives a request: an operation code, a 32-bit register number, a 32-bit write/set value and a 32-bit mask. It uses a valid/ready handshake. The block accepts one request at a time and returns a one-cycle done pulse with an error flag and the 32-bit read result. The block produces MDC from the system clock and drives MDIO itself through separate out, enable and in lines. It builds the preamble, start, opcode, addresses and turnaround. It releases the line for read turnaround and read data, and it detects a missing device from the turnaround bit. The read-modify-write operation reads a register, clears the masked bits, ORs in the set value and writes the result back.

Top module: `mdio_reg_master`

## Requirements
- R1: After reset `reqReady` is 1, `rspDone` is 0, `mdc` is 0 and `mdioOe` is 0.
- R2: Each frame carries, in order: 32 ones, start `01`, opcode (`01` write, `10` read), 5-bit PHY address, 5-bit register field, 2 turnaround bits (`10` driven on writes), and 16 data bits, most significant bit first. `mdioOut` changes only on a falling MDC edge. Read data is sampled on a rising edge. The MDC period is 2*HALF_DIV system clocks.
- R3: The register field is {switch id[2:0], sel, rw}. Bit 0 rw is 0 for write and 1 for read. Bit 1 sel is 0 for the address phase and 1 for the data phase.
- R4: Each 32-bit word is sent as two write frames to the same PHY and register field: bits 31:16 first, then bits 15:0.
- R5: A write request (`reqOp` = 01) sends four write frames. The register number goes with sel=0, rw=0. The write value goes with sel=1, rw=0.
- R6: A read request (`reqOp` = 00, and also 11) writes the register number with sel=0, rw=1. It then issues two read frames with sel=1, rw=1. The first read frame fills bits 31:16 of `rspRdData` and the second fills bits 15:0.
- R7: A read-modify-write request (`reqOp` = 10) does a full read and then a full write of (old & ~`reqMask`) | `reqWrData`. `rspRdData` returns the old value.
- R8: In a read frame `mdioOe` is 0 from the first turnaround bit to the end of the data. If the second turnaround bit is not sampled as 0, the access fails.
- R9: On a failed frame, no further frames are sent. For a read-modify-write this means the write is skipped. `rspErr` is 1 together with `rspDone`.
- R10: `reqReady` is 0 from the cycle after acceptance through the done cycle. A request that is held valid meanwhile is accepted only after done.
- R11: `rspDone` lasts exactly one system clock cycle.
- R12: The PHY address and switch id come from `cfgPhyAddr` and `cfgSwitchId` and are captured at acceptance. The usual switch PHY address is 0x1D, with switch id 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block idle, request can be taken |
| reqOp | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| reqRegNum | input | 32 | Switch register number |
| reqWrData | input | 32 | Write value, or set value for read-modify-write |
| reqMask | input | 32 | Bits cleared by read-modify-write |
| cfgPhyAddr | input | 5 | MDIO PHY address of the switch |
| cfgSwitchId | input | 3 | Switch id placed in the register field |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Access failed, valid with rspDone |
| rspRdData | output | 32 | Read result, valid with rspDone for reads without error |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO line as seen at the pad |

## Verification
The completion pulse of one access can fall in the same cycle as a new request that the host keeps valid. The bench sets up this case by holding `reqValid` high, with a new payload, through a whole write. It then checks that `reqReady` is low in the done cycle and rises on the next cycle. It checks that the waiting read is taken exactly once after that: one more done pulse, eight frames in all, and read data equal to the value just written. A bus-level switch model decodes every frame. It checks field order, the order of the halves and the release of the line in read frames. It can also be made absent, which exercises the abort paths.

// File: rtl/mdio_reg_pkg.sv
package mdio_reg_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int ID_W   = REG_W - 2;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_RMW   = 2'b10;

  typedef struct packed {
    logic load;     // capture request fields
    logic start;    // launch one frame
    logic rw;       // register field bit 0
    logic sel;      // register field bit 1
    logic lowHalf;  // 0: bits 31:16, 1: bits 15:0
    logic mergeWr;  // data phase sends merged read-modify-write value
  } ctrl_t;
endpackage

// File: rtl/mdio_frame_dp.sv
module mdio_frame_dp
  import mdio_reg_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] reqRegNum,
  input  logic [WORD_W-1:0] reqWrData,
  input  logic [WORD_W-1:0] reqMask,
  input  logic [PHY_W-1:0]  cfgPhyAddr,
  input  logic [ID_W-1:0]   cfgSwitchId,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              frameDone,
  output logic              frameErr,
  output logic [WORD_W-1:0] rdWord
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int DIV_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] LAST_HDR = BIT_W'(PRE_LEN + 13);
  localparam logic [BIT_W-1:0] TA2_BIT  = BIT_W'(PRE_LEN + 15);
  localparam logic [BIT_W-1:0] DAT_BIT  = BIT_W'(PRE_LEN + 16);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF_DIV - 1);

  logic [WORD_W-1:0]    regNumQ, wrDataQ, maskQ;
  logic [PHY_W-1:0]     phyQ;
  logic [ID_W-1:0]      idQ;
  logic [FRAME_LEN-1:0] shiftReg, frameWord;
  logic [BIT_W-1:0]     bitCnt;
  logic [DIV_W-1:0]     divCnt;
  logic [HALF_W-1:0]    rdShift;
  logic                 busy, rdFrame, lowQ, taErr, tick;

  // frame assembly for the frame about to be launched
  logic [WORD_W-1:0] srcWord;
  logic [HALF_W-1:0] halfData;
  logic [1:0]        opCode, taCode;
  logic              isRdFrame;

  always_comb begin
    isRdFrame = ctl.rw & ctl.sel;
    if (!ctl.sel)         srcWord = regNumQ;
    else if (ctl.mergeWr) srcWord = (rdWord & ~maskQ) | wrDataQ;
    else                  srcWord = wrDataQ;
    halfData = ctl.lowHalf ? srcWord[HALF_W-1:0] : srcWord[WORD_W-1:HALF_W];
    opCode   = isRdFrame ? 2'b10 : 2'b01;
    taCode   = isRdFrame ? 2'b11 : 2'b10;
    if (isRdFrame) halfData = '1;
    frameWord = {{PRE_LEN{1'b1}}, 2'b01, opCode, phyQ, idQ, ctl.sel, ctl.rw,
                 taCode, halfData};
  end

  assign tick    = busy && (divCnt == DIV_END);
  assign mdioOut = shiftReg[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regNumQ   <= '0;
      wrDataQ   <= '0;
      maskQ     <= '0;
      phyQ      <= '0;
      idQ       <= '0;
      rdWord    <= '0;
      shiftReg  <= '1;
      bitCnt    <= '0;
      divCnt    <= '0;
      rdShift   <= '0;
      busy      <= 1'b0;
      rdFrame   <= 1'b0;
      lowQ      <= 1'b0;
      taErr     <= 1'b0;
      mdc       <= 1'b0;
      mdioOe    <= 1'b0;
      frameDone <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (ctl.load) begin
        regNumQ <= reqRegNum;
        wrDataQ <= reqWrData;
        maskQ   <= reqMask;
        phyQ    <= cfgPhyAddr;
        idQ     <= cfgSwitchId;
        rdWord  <= '0;
      end
      if (ctl.start) begin
        busy     <= 1'b1;
        divCnt   <= '0;
        mdc      <= 1'b0;
        bitCnt   <= '0;
        shiftReg <= frameWord;
        rdFrame  <= isRdFrame;
        lowQ     <= ctl.lowHalf;
        mdioOe   <= 1'b1;
        taErr    <= 1'b0;
      end else if (busy) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          if (!mdc) begin
            // rising MDC edge: sample the line in read frames
            mdc <= 1'b1;
            if (rdFrame) begin
              if (bitCnt == TA2_BIT && mdioIn) taErr <= 1'b1;
              if (bitCnt >= DAT_BIT) rdShift <= {rdShift[HALF_W-2:0], mdioIn};
            end
          end else begin
            // falling MDC edge: advance to the next bit
            mdc <= 1'b0;
            if (bitCnt == LAST_BIT) begin
              busy      <= 1'b0;
              mdioOe    <= 1'b0;
              shiftReg  <= '1;
              frameDone <= 1'b1;
              frameErr  <= taErr;
              if (rdFrame && !taErr) begin
                if (lowQ) rdWord[HALF_W-1:0]      <= rdShift;
                else      rdWord[WORD_W-1:HALF_W] <= rdShift;
              end
            end else begin
              bitCnt   <= bitCnt + 1'b1;
              shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b1};
              if (rdFrame && bitCnt == LAST_HDR) mdioOe <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       frameDone,
  input  logic       frameErr,
  output logic       reqReady,
  output logic       rspDone,
  output logic       rspErr,
  output ctrl_t      ctl
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} state_t;

  state_t     state;
  logic [1:0] step;
  logic       grpRead, rmwQ, errQ;

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == S_IDLE) && reqValid;
    ctl.start   = (state == S_ISSUE);
    ctl.rw      = grpRead;
    ctl.sel     = step[1];
    ctl.lowHalf = step[0];
    ctl.mergeWr = rmwQ && !grpRead;
  end

  assign reqReady = (state == S_IDLE);
  assign rspDone  = (state == S_FIN);
  assign rspErr   = rspDone && errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      step    <= '0;
      grpRead <= 1'b0;
      rmwQ    <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          rmwQ    <= (reqOp == OP_RMW);
          grpRead <= (reqOp != OP_WRITE);
          step    <= '0;
          errQ    <= 1'b0;
          state   <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (frameDone) begin
          if (frameErr) begin
            errQ  <= 1'b1;
            state <= S_FIN;
          end else if (step == 2'd3) begin
            if (grpRead && rmwQ) begin
              grpRead <= 1'b0;
              step    <= '0;
              state   <= S_ISSUE;
            end else begin
              state <= S_FIN;
            end
          end else begin
            step  <= step + 1'b1;
            state <= S_ISSUE;
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdio_reg_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqOp,
  input  logic [31:0] reqRegNum,
  input  logic [31:0] reqWrData,
  input  logic [31:0] reqMask,
  input  logic [4:0]  cfgPhyAddr,
  input  logic [2:0]  cfgSwitchId,
  output logic        rspDone,
  output logic        rspErr,
  output logic [31:0] rspRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  ctrl_t ctl;
  logic  frameDone, frameErr;

  mdio_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .frameDone (frameDone),
    .frameErr  (frameErr),
    .reqReady  (reqReady),
    .rspDone   (rspDone),
    .rspErr    (rspErr),
    .ctl       (ctl)
  );

  mdio_frame_dp #(.HALF_DIV(HALF_DIV), .PRE_LEN(PRE_LEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqRegNum   (reqRegNum),
    .reqWrData   (reqWrData),
    .reqMask     (reqMask),
    .cfgPhyAddr  (cfgPhyAddr),
    .cfgSwitchId (cfgSwitchId),
    .mdioIn      (mdioIn),
    .mdc         (mdc),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe),
    .frameDone   (frameDone),
    .frameErr    (frameErr),
    .rdWord      (rspRdData)
  );
endmodule

// File: rtl/mdio_reg_master_chk.sv
module mdio_reg_master_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic rspDone,
  input logic rspErr,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe
);
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_not_ready_at_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> !reqReady);

  // output moves only when MDC falls: stable whenever MDC is (or became) high
  p_out_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> $stable(mdioOut));

  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!mdc && !mdioOe));

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);
endmodule

bind mdio_reg_master mdio_reg_master_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspDone  (rspDone),
  .rspErr   (rspErr),
  .mdc      (mdc),
  .mdioOut  (mdioOut),
  .mdioOe   (mdioOe)
);

// File: tb/mdio_reg_master_bench.sv
`timescale 1ns/1ps
module mdio_reg_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'b00;
  logic [31:0] reqRegNum = '0, reqWrData = '0, reqMask = '0;
  logic [4:0]  cfgPhyAddr = 5'h1D;
  logic [2:0]  cfgSwitchId = 3'd0;
  logic        rspDone, rspErr;
  logic [31:0] rspRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;
  logic        slv = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign mdioIn = mdioOe ? mdioOut : slv;

  mdio_reg_master u_mdio_reg_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqRegNum(reqRegNum), .reqWrData(reqWrData),
    .reqMask(reqMask), .cfgPhyAddr(cfgPhyAddr), .cfgSwitchId(cfgSwitchId),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdData(rspRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // ---------------- switch model on the MDIO bus ----------------
  logic [4:0]  modelPhy = 5'h1D;
  logic [2:0]  modelId = 3'd0;
  logic        absent = 1'b0;
  logic [31:0] mem [16];
  logic [31:0] addrLatch = '0;
  logic [15:0] hiTmp = '0, rdVal = '0;
  logic        wrHalf = 1'b0, rdHalf = 1'b0, hit = 1'b0, oeInRead = 1'b0;
  logic [11:0] hdr = '0;
  logic [17:0] body = '0;
  logic [4:0]  fieldLog [16];
  logic [1:0]  opLog [16];
  int mSt = 0, ones = 0, hdrCnt = 0, bodyCnt = 0, frameCnt = 0;

  always @(posedge mdc) begin
    case (mSt)
      0: begin
        if (mdioOe && mdioOut) ones++;
        else if (mdioOe && !mdioOut && ones >= 32) mSt = 1;
        else ones = 0;
      end
      1: begin
        if (mdioOe && mdioOut) begin mSt = 2; hdrCnt = 0; end
        else begin mSt = 0; ones = 0; end
      end
      2: begin
        hdr = {hdr[10:0], mdioOut};
        hdrCnt++;
        if (hdrCnt == 12) begin
          bodyCnt = 0;
          hit = (hdr[9:5] == modelPhy) && (hdr[4:2] == modelId) && !absent;
          fieldLog[frameCnt % 16] = hdr[4:0];
          opLog[frameCnt % 16] = hdr[11:10];
          frameCnt++;
          if (hdr[11:10] == 2'b10) begin
            mSt = 4;
            if (hit) begin
              rdVal  = rdHalf ? mem[addrLatch[3:0]][15:0] : mem[addrLatch[3:0]][31:16];
              rdHalf = !rdHalf;
            end
          end else begin
            mSt = 3;
          end
        end
      end
      3: begin
        body = {body[16:0], mdioOut};
        bodyCnt++;
        if (bodyCnt == 18) begin
          if (hit) begin
            if (!wrHalf) begin
              hiTmp = body[15:0];
              wrHalf = 1'b1;
            end else begin
              wrHalf = 1'b0;
              if (!hdr[1]) begin
                addrLatch = {hiTmp, body[15:0]};
                rdHalf = 1'b0;
              end else if (!hdr[0]) begin
                mem[addrLatch[3:0]] = {hiTmp, body[15:0]};
              end
            end
          end
          mSt = 0; ones = 0;
        end
      end
      default: begin
        if (mdioOe) oeInRead = 1'b1;
        bodyCnt++;
        if (bodyCnt == 18) begin mSt = 0; ones = 0; end
      end
    endcase
  end

  always @(negedge mdc) begin
    slv = 1'b1;
    if (mSt == 4 && hit) begin
      if (bodyCnt == 1) slv = 1'b0;
      else if (bodyCnt >= 2 && bodyCnt < 18) slv = rdVal[17 - bodyCnt];
    end
  end

  // ---------------- bench helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [1:0] op, input logic [31:0] rn, input logic [31:0] wd,
                       input logic [31:0] mk, output logic [31:0] rd, output logic err);
    @(negedge clk);
    reqOp = op; reqRegNum = rn; reqWrData = wd; reqMask = mk; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 ready low after accept", {31'd0, reqReady}, 32'd0);
    while (!rspDone) @(negedge clk);
    rd = rspRdData; err = rspErr;
    chk("R10 ready low in done cycle", {31'd0, reqReady}, 32'd0);
    @(negedge clk);
    chk("R11 done lasts one cycle", {31'd0, rspDone}, 32'd0);
  endtask

  task automatic chkField(input int idx, input logic [4:0] expF, input logic [1:0] expOp, input string tag);
    chk({tag, " field"}, {27'd0, fieldLog[idx % 16]}, {27'd0, expF});
    chk({tag, " opcode"}, {30'd0, opLog[idx % 16]}, {30'd0, expOp});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1 ready after reset", {31'd0, reqReady}, 32'd1);
    chk("R1 done after reset", {31'd0, rspDone}, 32'd0);
    chk("R1 mdc after reset", {31'd0, mdc}, 32'd0);
    chk("R1 oe after reset", {31'd0, mdioOe}, 32'd0);
  endtask

  task automatic t_write;
    logic [31:0] rd; logic err; int base; time t0, per;
    base = frameCnt;
    fork
      doReq(2'b01, 32'h0008_0403, 32'hA5C3_1E7F, 32'h0, rd, err);
      begin @(posedge mdc); t0 = $time; @(posedge mdc); per = $time - t0; end
    join
    chk("R2 MDC period 20ns", 32'(per), 32'd20);
    chk("R5 write no error", {31'd0, err}, 32'd0);
    chk("R5 four frames", 32'(frameCnt - base), 32'd4);
    chk("R4 register number delivered hi/lo", addrLatch, 32'h0008_0403);
    chk("R4 data delivered hi/lo", mem[3], 32'hA5C3_1E7F);
    chkField(base,     5'b000_0_0, 2'b01, "R3 write addr hi");
    chkField(base + 1, 5'b000_0_0, 2'b01, "R3 write addr lo");
    chkField(base + 2, 5'b000_1_0, 2'b01, "R5 write data hi");
    chkField(base + 3, 5'b000_1_0, 2'b01, "R5 write data lo");
  endtask

  task automatic t_read;
    logic [31:0] rd; logic err; int base;
    base = frameCnt;
    oeInRead = 1'b0;
    doReq(2'b00, 32'h0008_0403, 32'hFFFF_FFFF, 32'h0, rd, err);
    chk("R6 read data", rd, 32'hA5C3_1E7F);
    chk("R6 read no error", {31'd0, err}, 32'd0);
    chk("R8 line released in read frames", {31'd0, oeInRead}, 32'd0);
    chkField(base,     5'b000_0_1, 2'b01, "R6 read addr hi");
    chkField(base + 1, 5'b000_0_1, 2'b01, "R6 read addr lo");
    chkField(base + 2, 5'b000_1_1, 2'b10, "R6 read data hi");
    chkField(base + 3, 5'b000_1_1, 2'b10, "R6 read data lo");
    // op 11 behaves as read
    doReq(2'b11, 32'h0008_0403, 32'h0, 32'h0, rd, err);
    chk("R6 op 11 reads", rd, 32'hA5C3_1E7F);
  endtask

  task automatic t_rmw;
    logic [31:0] rd; logic err; int base;
    doReq(2'b01, 32'h0000_0405, 32'h1234_5678, 32'h0, rd, err);
    base = frameCnt;
    doReq(2'b10, 32'h0000_0405, 32'h0000_3400, 32'h0000_FF00, rd, err);
    chk("R7 rmw returns old value", rd, 32'h1234_5678);
    chk("R7 rmw no error", {31'd0, err}, 32'd0);
    chk("R7 rmw merged value", mem[5], 32'h1234_3478);
    chk("R7 rmw eight frames", 32'(frameCnt - base), 32'd8);
    chkField(base + 4, 5'b000_0_0, 2'b01, "R7 rmw write addr");
    chkField(base + 7, 5'b000_1_0, 2'b01, "R7 rmw write data");
  endtask

  task automatic t_absent;
    logic [31:0] rd; logic err; int base;
    absent = 1'b1;
    base = frameCnt;
    doReq(2'b00, 32'h0000_0405, 32'h0, 32'h0, rd, err);
    chk("R8 missing device flags error", {31'd0, err}, 32'd1);
    chk("R9 read aborted after first read frame", 32'(frameCnt - base), 32'd3);
    base = frameCnt;
    doReq(2'b10, 32'h0000_0405, 32'hFFFF_FFFF, 32'hFFFF_FFFF, rd, err);
    chk("R9 rmw error", {31'd0, err}, 32'd1);
    chk("R9 rmw write skipped", 32'(frameCnt - base), 32'd3);
    absent = 1'b0;
    chk("R9 rmw target unchanged", mem[5], 32'h1234_3478);
  endtask

  task automatic t_cfg;
    logic [31:0] rd; logic err; int base;
    modelId = 3'd5; modelPhy = 5'h03;
    cfgSwitchId = 3'd5; cfgPhyAddr = 5'h03;
    base = frameCnt;
    doReq(2'b01, 32'h0000_0409, 32'hCAFE_0101, 32'h0, rd, err);
    chkField(base, 5'b101_0_0, 2'b01, "R12 switch id in field");
    doReq(2'b00, 32'h0000_0409, 32'h0, 32'h0, rd, err);
    chk("R12 configured address reads back", rd, 32'hCAFE_0101);
    chk("R12 configured address no error", {31'd0, err}, 32'd0);
    cfgSwitchId = 3'd2;
    doReq(2'b00, 32'h0000_0409, 32'h0, 32'h0, rd, err);
    chk("R12 wrong switch id fails", {31'd0, err}, 32'd1);
    modelId = 3'd0; modelPhy = 5'h1D;
    cfgSwitchId = 3'd0; cfgPhyAddr = 5'h1D;
  endtask

  task automatic t_b2b;
    int base, dones;
    base = frameCnt;
    dones = 0;
    @(negedge clk);
    reqOp = 2'b01; reqRegNum = 32'h0000_0407; reqWrData = 32'h0BAD_F00D; reqMask = '0;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqOp = 2'b00; reqWrData = 32'h0;  // second request kept pending
    while (!rspDone) @(negedge clk);
    dones++;
    chk("R10 held request not taken in done cycle", {31'd0, reqReady}, 32'd0);
    @(negedge clk);
    chk("R11 done single with pending request", {31'd0, rspDone}, 32'd0);
    chk("R10 ready returns after done", {31'd0, reqReady}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 pending request accepted once", {31'd0, reqReady}, 32'd0);
    while (!rspDone) @(negedge clk);
    dones++;
    chk("R10 pending read data", rspRdData, 32'h0BAD_F00D);
    @(negedge clk);
    chk("R10 two completions", 32'(dones), 32'd2);
    chk("R10 eight frames for two requests", 32'(frameCnt - base), 32'd8);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_rmw();
    t_absent();
    t_cfg();
    t_b2b();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule